// File: doc/BRIEF.md
# Decode Group Issue Controller

This block is the cycle-level decode stage of an out-of-order front end. Instructions arrive one per cycle on a valid/ready input. Each carries a tag and a micro-op count. Short instructions go into a bank of parallel decoder slots. They leave in program order over a valid/ready output, one instruction per handshake. Long instructions go to a microcode sequencer, which works alone and emits two micro-ops per accepted output beat.

Acceptance looks at two things together: how many slots are occupied and the combined micro-op count of their contents. This keeps each decode group within the per-cycle micro-op budget. A long instruction must wait until everything older has left. While it is being sequenced, nothing else is taken in. Released slots are reclaimed lazily: trailing empties are trimmed each cycle, and a run of leading empties is shifted out only once it makes up at least half of the list.

Top module: `decode_group_issue`

## Requirements
- R1: An instruction whose micro-op count is greater than 2 is microcoded, and its output beats carry `out_mc_o`=1. An instruction with a count of 0, 1 or 2 is plain. It leaves as a single beat with `out_mc_o`=0 and `out_last_o`=1.
- R2: At most 4 plain instructions are held. With 4 held, `in_ready_o` is low for a plain instruction.
- R3: A plain instruction is refused when the counts of the held plain instructions, plus its own count, add up to more than 4. A count of 0 is taken as 1 in this sum.
- R4: While the sequencer holds an instruction, `in_ready_o` is low for every input.
- R5: A microcoded instruction is accepted only when `busy_o` is low.
- R6: A microcoded instruction with n micro-ops leaves as ceil(n/2) accepted beats. All of its beats carry its tag, and `out_last_o`=1 marks the final beat. A beat presented while `out_ready_i` is low does not use up any micro-ops.
- R7: Plain instructions leave in acceptance order, one per output handshake. While `out_ready_i` is low, the presented beat keeps its tag, kind and last flag.
- R8: An instruction accepted at a clock edge appears at the output from that edge on, and no earlier. Acceptance depends only on the state held at the start of the cycle and on `in_uops_i`. A release in the same cycle does not free room for it.
- R9: `busy_o` is high exactly while a slot or the sequencer holds an instruction. `out_valid_o` is never high while `busy_o` is low.
- R10: While `rst_ni` is low, the block empties. After reset, `busy_o` and `out_valid_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Instruction offered |
| in_ready_o | output | 1 | Instruction can be accepted this cycle |
| in_tag_i | input | TAG_W | Instruction tag |
| in_uops_i | input | UOP_W | Micro-op count of the offered instruction |
| out_valid_o | output | 1 | A beat is presented |
| out_ready_i | input | 1 | Next stage takes the beat |
| out_tag_o | output | TAG_W | Tag of the presented instruction |
| out_mc_o | output | 1 | Beat comes from the microcode sequencer |
| out_last_o | output | 1 | Final beat of the instruction |
| busy_o | output | 1 | Any instruction held |

## Verification
`in_ready_o` is combinational in the same cycle. It comes from the registered occupancy and the offered count, so the bench samples it shortly after driving the inputs, before the edge. An instruction accepted at an edge must show on `out_valid_o`/`out_tag_o` in the sample taken right after that edge, and not one cycle later. The bench model therefore pushes and pops its queue only once that edge has passed. Sequencer beats count down once per cycle in which `out_ready_i` is high. The model decrements the remaining beat count only on those handshakes, and it expects `out_last_o` in the sample where one beat remains.

// File: rtl/dgi_pkg.sv
package dgi_pkg;
  // budget weight of an instruction: an empty count still occupies a decoder
  function automatic int unsigned eff_uops(input int unsigned u);
    return (u == 0) ? 1 : u;
  endfunction
endpackage

// File: rtl/dgi_slot_bank.sv
module dgi_slot_bank #(
  parameter int SLOTS = 4,
  parameter int UOP_W = 4,
  parameter int TAG_W = 8,
  parameter int SUM_W = 8,
  localparam int DEPTH = 2 * SLOTS,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int LEN_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [TAG_W-1:0] push_tag_i,
  input  logic [UOP_W-1:0] push_uops_i,
  input  logic             pop_i,
  output logic             head_valid_o,
  output logic [TAG_W-1:0] head_tag_o,
  output logic [LEN_W-1:0] used_o,
  output logic [SUM_W-1:0] sum_o,
  output logic [LEN_W-1:0] len_o
);
  logic             vld_q [DEPTH];
  logic [TAG_W-1:0] tag_q [DEPTH];
  logic [UOP_W-1:0] uop_q [DEPTH];
  logic [LEN_W-1:0] len_q;

  logic             vld_n [DEPTH];
  logic [TAG_W-1:0] tag_n [DEPTH];
  logic [UOP_W-1:0] uop_n [DEPTH];
  logic [LEN_W-1:0] len_n;

  logic [IDX_W-1:0] head_idx;
  logic             head_found;

  // oldest valid entry; holes only ever form a prefix
  always_comb begin
    head_idx   = '0;
    head_found = 1'b0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (vld_q[i]) begin
        head_idx   = IDX_W'(i);
        head_found = 1'b1;
      end
    end
  end

  assign head_valid_o = head_found;
  assign head_tag_o   = tag_q[head_idx];
  assign len_o        = len_q;

  always_comb begin
    used_o = '0;
    sum_o  = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (vld_q[i]) begin
        used_o = used_o + LEN_W'(1);
        sum_o  = sum_o + SUM_W'(dgi_pkg::eff_uops(32'(uop_q[i])));
      end
    end
  end

  logic             v1 [DEPTH];
  logic [LEN_W-1:0] len1, lead1, sh;
  logic [LEN_W:0]   lead2x;

  always_comb begin
    for (int i = 0; i < DEPTH; i++) v1[i] = vld_q[i];
    if (pop_i) v1[head_idx] = 1'b0;
    // trim released entries at the tail
    len1 = '0;
    for (int i = 0; i < DEPTH; i++) if (v1[i]) len1 = LEN_W'(i + 1);
    lead1 = len1;
    for (int i = DEPTH - 1; i >= 0; i--) if (v1[i]) lead1 = LEN_W'(i);
    // compact the leading holes only once they are at least half the list
    lead2x = {lead1, 1'b0};
    sh     = (lead2x >= {1'b0, len1}) ? lead1 : '0;
    for (int i = 0; i < DEPTH; i++) begin
      vld_n[i] = 1'b0;
      tag_n[i] = tag_q[i];
      uop_n[i] = uop_q[i];
      if (i + int'(sh) < DEPTH) begin
        vld_n[i] = v1[i + int'(sh)];
        tag_n[i] = tag_q[i + int'(sh)];
        uop_n[i] = uop_q[i + int'(sh)];
      end
    end
    len_n = len1 - sh;
    if (push_i && (int'(len_n) < DEPTH)) begin
      vld_n[IDX_W'(len_n)] = 1'b1;
      tag_n[IDX_W'(len_n)] = push_tag_i;
      uop_n[IDX_W'(len_n)] = push_uops_i;
      len_n = len_n + LEN_W'(1);
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_q[g] <= 1'b0;
        tag_q[g] <= '0;
        uop_q[g] <= '0;
      end else begin
        vld_q[g] <= vld_n[g];
        tag_q[g] <= tag_n[g];
        uop_q[g] <= uop_n[g];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) len_q <= '0;
    else         len_q <= len_n;
  end
endmodule

// File: rtl/dgi_mc_seq.sv
module dgi_mc_seq #(
  parameter int UOP_W = 4,
  parameter int TAG_W = 8,
  parameter int RATE  = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [TAG_W-1:0] start_tag_i,
  input  logic [UOP_W-1:0] start_uops_i,
  input  logic             adv_i,
  output logic             active_o,
  output logic [TAG_W-1:0] tag_o,
  output logic             last_o
);
  logic             act_q;
  logic [UOP_W-1:0] left_q;
  logic [TAG_W-1:0] tag_q;

  assign active_o = act_q;
  assign tag_o    = tag_q;
  assign last_o   = (left_q <= UOP_W'(RATE));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= 1'b0;
      left_q <= '0;
      tag_q  <= '0;
    end else if (start_i) begin
      act_q  <= 1'b1;
      left_q <= start_uops_i;
      tag_q  <= start_tag_i;
    end else if (act_q && adv_i) begin
      if (last_o) act_q <= 1'b0;
      else        left_q <= left_q - UOP_W'(RATE);
    end
  end
endmodule

// File: rtl/decode_group_issue.sv
module decode_group_issue #(
  parameter int TAG_W      = 8,
  parameter int UOP_W      = 4,
  parameter int SLOTS      = 4,
  parameter int UOP_BUDGET = 4,
  parameter int MC_THRESH  = 2,
  parameter int MC_RATE    = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_valid_i,
  output logic             in_ready_o,
  input  logic [TAG_W-1:0] in_tag_i,
  input  logic [UOP_W-1:0] in_uops_i,
  output logic             out_valid_o,
  input  logic             out_ready_i,
  output logic [TAG_W-1:0] out_tag_o,
  output logic             out_mc_o,
  output logic             out_last_o,
  output logic             busy_o
);
  localparam int DEPTH = 2 * SLOTS;
  localparam int LEN_W = $clog2(DEPTH + 1);
  localparam int SUM_W = UOP_W + $clog2(DEPTH + 1) + 1;

  logic             head_valid, mc_act, mc_last;
  logic [TAG_W-1:0] head_tag, mc_tag;
  logic [LEN_W-1:0] used_cnt, bank_len;
  logic [SUM_W-1:0] uop_sum, in_eff;
  logic             in_is_mc, plain_ok, mc_ok, fire, push, start, pop, adv;

  assign in_is_mc = in_uops_i > UOP_W'(MC_THRESH);
  assign in_eff   = SUM_W'(dgi_pkg::eff_uops(32'(in_uops_i)));
  assign busy_o   = mc_act | (used_cnt != '0);

  assign plain_ok   = !mc_act && (used_cnt < LEN_W'(SLOTS))
                      && ((uop_sum + in_eff) <= SUM_W'(UOP_BUDGET));
  assign mc_ok      = !busy_o;
  assign in_ready_o = in_is_mc ? mc_ok : plain_ok;

  assign fire  = in_valid_i & in_ready_o;
  assign push  = fire & ~in_is_mc;
  assign start = fire & in_is_mc;
  assign pop   = head_valid & out_ready_i & ~mc_act;
  assign adv   = mc_act & out_ready_i;

  dgi_slot_bank #(
    .SLOTS(SLOTS), .UOP_W(UOP_W), .TAG_W(TAG_W), .SUM_W(SUM_W)
  ) u_bank (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (push),
    .push_tag_i  (in_tag_i),
    .push_uops_i (in_uops_i),
    .pop_i       (pop),
    .head_valid_o(head_valid),
    .head_tag_o  (head_tag),
    .used_o      (used_cnt),
    .sum_o       (uop_sum),
    .len_o       (bank_len)
  );

  dgi_mc_seq #(
    .UOP_W(UOP_W), .TAG_W(TAG_W), .RATE(MC_RATE)
  ) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start),
    .start_tag_i (in_tag_i),
    .start_uops_i(in_uops_i),
    .adv_i       (adv),
    .active_o    (mc_act),
    .tag_o       (mc_tag),
    .last_o      (mc_last)
  );

  assign out_valid_o = mc_act | head_valid;
  assign out_mc_o    = mc_act;
  assign out_tag_o   = mc_act ? mc_tag : head_tag;
  assign out_last_o  = mc_act ? mc_last : 1'b1;
endmodule

// File: rtl/decode_group_issue_chk.sv
module decode_group_issue_chk #(
  parameter int TAG_W     = 8,
  parameter int UOP_W     = 4,
  parameter int SLOTS     = 4,
  parameter int MC_THRESH = 2,
  localparam int LEN_W    = $clog2(2 * SLOTS + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             in_valid_i,
  input logic             in_ready_o,
  input logic [UOP_W-1:0] in_uops_i,
  input logic             out_valid_o,
  input logic             out_ready_i,
  input logic [TAG_W-1:0] out_tag_o,
  input logic             out_mc_o,
  input logic             out_last_o,
  input logic             busy_o,
  input logic [LEN_W-1:0] used_cnt,
  input logic [LEN_W-1:0] bank_len
);
  // R2
  slot_cap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && in_ready_o && (in_uops_i <= UOP_W'(MC_THRESH)) |-> used_cnt < LEN_W'(SLOTS));
  // R2
  list_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bank_len <= LEN_W'(2 * SLOTS));
  // R4
  mc_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_mc_o |-> !in_ready_o);
  // R5
  mc_drain_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && in_ready_o && (in_uops_i > UOP_W'(MC_THRESH)) |-> !busy_o);
  // R6
  mc_cont_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_mc_o && out_ready_i && !out_last_o |=> out_mc_o && $stable(out_tag_o));
  // R7
  stall_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_tag_o)
      && $stable(out_mc_o) && $stable(out_last_o));
  // R9
  idle_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !out_valid_o);
endmodule

bind decode_group_issue decode_group_issue_chk #(
  .TAG_W(TAG_W), .UOP_W(UOP_W), .SLOTS(SLOTS), .MC_THRESH(MC_THRESH)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .in_valid_i (in_valid_i),
  .in_ready_o (in_ready_o),
  .in_uops_i  (in_uops_i),
  .out_valid_o(out_valid_o),
  .out_ready_i(out_ready_i),
  .out_tag_o  (out_tag_o),
  .out_mc_o   (out_mc_o),
  .out_last_o (out_last_o),
  .busy_o     (busy_o),
  .used_cnt   (used_cnt),
  .bank_len   (bank_len)
);

// File: tb/sim_decode_group_issue.sv
`timescale 1ns/1ps
module sim_decode_group_issue;
  localparam int TAG_W = 8;
  localparam int UOP_W = 4;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #2.5 clk = ~clk;

  logic             in_valid_i = 1'b0, in_ready_o;
  logic [TAG_W-1:0] in_tag_i = '0;
  logic [UOP_W-1:0] in_uops_i = '0;
  logic             out_valid_o, out_ready_i = 1'b0, out_mc_o, out_last_o, busy_o;
  logic [TAG_W-1:0] out_tag_o;

  decode_group_issue u0 (
    .clk_i(clk), .rst_ni(rst_ni),
    .in_valid_i(in_valid_i), .in_ready_o(in_ready_o),
    .in_tag_i(in_tag_i), .in_uops_i(in_uops_i),
    .out_valid_o(out_valid_o), .out_ready_i(out_ready_i),
    .out_tag_o(out_tag_o), .out_mc_o(out_mc_o),
    .out_last_o(out_last_o), .busy_o(busy_o)
  );

  int n_vec = 0, n_bad = 0;
  int tag_ctr = 1;
  logic [TAG_W-1:0] q_tag[$];
  int               q_beats[$];
  bit               q_mc[$];
  int               q_eff[$];

  function automatic int eff(input int u);
    return (u == 0) ? 1 : u;
  endfunction

  function automatic bit exp_ready(input int u);
    int s = 0;
    if (q_mc.size() > 0 && q_mc[0]) return 1'b0;
    if (u > 2) return q_tag.size() == 0;
    if (q_tag.size() >= 4) return 1'b0;
    foreach (q_eff[i]) s += q_eff[i];
    return (s + eff(u)) <= 4;
  endfunction

  function automatic string rdy_req(input int u);
    if (q_mc.size() > 0 && q_mc[0]) return "R4";
    if (u > 2) return "R5";
    if (q_tag.size() >= 4) return "R2";
    return "R3";
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
  endtask

  task automatic step(input bit v, input int u, input bit rdy);
    bit er, in_fire, out_fire;
    @(negedge clk);
    in_valid_i  = v;
    in_uops_i   = UOP_W'(u);
    in_tag_i    = TAG_W'(tag_ctr);
    out_ready_i = rdy;
    #1;
    er = exp_ready(u);
    chk(rdy_req(u), int'(in_ready_o), int'(er));
    chk("R9", int'(busy_o), int'(q_tag.size() > 0));
    chk("R8", int'(out_valid_o), int'(q_tag.size() > 0));
    if (q_tag.size() > 0) begin
      chk("R1", int'(out_mc_o), int'(q_mc[0]));
      if (q_mc[0]) begin
        chk("R6", int'(out_tag_o), int'(q_tag[0]));
        chk("R6", int'(out_last_o), int'(q_beats[0] == 1));
      end else begin
        chk("R7", int'(out_tag_o), int'(q_tag[0]));
        chk("R7", int'(out_last_o), 1);
      end
    end
    in_fire  = v && er;
    out_fire = (q_tag.size() > 0) && rdy;
    @(posedge clk);
    if (out_fire) begin
      if (q_beats[0] > 1) q_beats[0] = q_beats[0] - 1;
      else begin
        void'(q_tag.pop_front()); void'(q_beats.pop_front());
        void'(q_mc.pop_front());  void'(q_eff.pop_front());
      end
    end
    if (in_fire) begin
      q_tag.push_back(TAG_W'(tag_ctr));
      q_beats.push_back(u > 2 ? (u + 1) / 2 : 1);
      q_mc.push_back(u > 2);
      q_eff.push_back(eff(u));
      tag_ctr = (tag_ctr + 1) % 256;
    end
  endtask

  task automatic drain();
    for (int i = 0; i < 12; i++) step(1'b0, 0, 1'b1);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    // R10 state during and after reset
    chk("R10", int'(busy_o), 0);
    chk("R10", int'(out_valid_o), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R10", int'(busy_o), 0);
    chk("R10", int'(out_valid_o), 0);

    // R2: four singles fill the slots, a fifth is refused
    for (int i = 0; i < 5; i++) step(1'b1, 1, 1'b0);
    drain();
    // R3: zero counts weigh one each
    for (int i = 0; i < 5; i++) step(1'b1, 0, 1'b0);
    drain();
    // R3: 2-2 then a single is refused; 2-1-1 then a single is refused
    step(1'b1, 2, 1'b0); step(1'b1, 2, 1'b0); step(1'b1, 1, 1'b0);
    drain();
    step(1'b1, 2, 1'b0); step(1'b1, 1, 1'b0); step(1'b1, 1, 1'b0); step(1'b1, 1, 1'b0);
    drain();
    // R8: release in the same cycle does not free room
    for (int i = 0; i < 4; i++) step(1'b1, 1, 1'b0);
    step(1'b1, 1, 1'b1);
    drain();
    // R5: microcoded waits for older plain work to drain
    step(1'b1, 1, 1'b0); step(1'b1, 3, 1'b0); step(1'b1, 3, 1'b1);
    step(1'b1, 3, 1'b1); step(1'b1, 3, 1'b1);
    drain();
    // R4/R6: five micro-ops with stalls, input offered throughout
    step(1'b1, 5, 1'b0);
    step(1'b1, 1, 1'b0); step(1'b1, 1, 1'b1); step(1'b1, 1, 1'b0);
    step(1'b1, 1, 1'b1); step(1'b1, 1, 1'b1); step(1'b1, 1, 1'b1);
    drain();
    // R6: largest count runs eight beats
    step(1'b1, 15, 1'b1);
    drain();
    // R1: count 2 stays plain
    step(1'b1, 2, 1'b1);
    drain();

    for (int n = 0; n < 4000; n++) begin
      bit v, r;
      int u;
      v = ($urandom_range(0, 9) < 7);
      r = ($urandom_range(0, 9) < 7);
      u = ($urandom_range(0, 9) < 8) ? int'($urandom_range(0, 3)) : int'($urandom_range(0, 15));
      step(v, u, r);
    end
    drain();
    summary();
    $finish;
  end
endmodule